// File: doc/BRIEF.md
# Set-Dueling Insertion Policy Controller

This block decides where a newly filled cache line enters the recency stack. Two insertion policies compete. The plain policy always puts a fill at the most-recently-used (MRU) end. The bimodal policy puts a fill at the least-recently-used (LRU) end and only rarely, at a throttled rate, at MRU. A small group of sets always uses the plain policy and another small group always uses the bimodal policy. Misses in these two groups move one shared saturating selector counter in opposite directions. Every other set follows whichever policy is currently taking fewer misses.

Each access carries a set index and a hit/miss flag. It arrives on a valid/ready stream and produces a decision on a matching stream in the same cycle. The decision gives fill-versus-hit, insert-at-MRU versus insert-at-LRU, and promote-on-hit. Back-pressure passes straight through: `acc_ready` equals `dec_ready`. An access takes effect only in a cycle where `acc_valid` and `dec_ready` are both high. While the access is stalled, its decision outputs hold, and neither the selector counter nor the throttle generator moves. The recency stack and the tag lookup belong to the surrounding cache.

Top module: `sdip_insert_ctrl`

## Requirements
- R1: With K = SET_W/2, a set is a plain-policy leader when index bits [K-1:0] equal bits [2K-1:K]. It is a bimodal-policy leader when bits [K-1:0] equal the bitwise inverse of bits [2K-1:K]. Every other set is a follower.
- R2: An accepted miss in a plain-policy leader increments the selector counter. The counter saturates at 2^CNT_W-1 and does not wrap.
- R3: An accepted miss in a bimodal-policy leader decrements the selector counter. The counter saturates at 0 and does not wrap.
- R4: The selector counter resets to 2^(CNT_W-1). `pol_bip` is the counter's MSB, so it reads 1 after reset.
- R5: A follower uses the plain policy when `pol_bip` is 0 and the bimodal policy when it is 1. Leaders always use their own policy, whatever `pol_bip` is.
- R6: The plain policy gives `dec_ins_mru`=1 on every miss. The bimodal policy gives `dec_ins_mru`=1 on a miss only when the low EPS_W bits of the throttle generator are all zero, which is a rate of 1/32 by default.
- R7: The throttle generator is a 16-bit shift register that resets to 0xACE1. On each accepted miss it shifts left and takes `s[15]^s[13]^s[12]^s[10]` into bit 0. It holds in every other cycle.
- R8: A hit gives `dec_promote`=1, `dec_fill`=0 and `dec_ins_mru`=0. A hit changes neither the counter nor the throttle generator.
- R9: `acc_ready` equals `dec_ready` and `dec_valid` equals `acc_valid`. Without both `acc_valid` and `dec_ready`, no state changes.
- R10: A miss in a follower set leaves the selector counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present |
| acc_ready | output | 1 | Access accepted (equals dec_ready) |
| acc_set | input | SET_W | Set index of the access |
| acc_hit | input | 1 | 1 for a hit, 0 for a miss |
| dec_valid | output | 1 | Decision present |
| dec_ready | input | 1 | Consumer takes the decision |
| dec_fill | output | 1 | Access is a miss and needs a fill |
| dec_ins_mru | output | 1 | Fill enters at MRU (0: at LRU) |
| dec_promote | output | 1 | Hit line moves to MRU |
| pol_bip | output | 1 | Follower policy: 1 bimodal, 0 plain |

## Verification
The bench runs a miss through every set index. This separates the three set roles, because each role's insertion decision and counter effect differ. Long runs of misses on a single leader push the counter past both rails. The bench then counts how many opposite misses it takes to flip `pol_bip`, which tells saturation apart from wrap-around. Streams of hits and stalled or invalid accesses come next. Every later insertion decision depends on the exact counter and throttle state, so any spurious update shows up in those later decisions. A pseudo-random mix of sets, hits and stalls runs last, with the counter and the throttle generator tracked arithmetically in the bench.

// File: rtl/sdip_pkg.sv
package sdip_pkg;
  typedef enum logic [1:0] {
    ROLE_FOLLOW   = 2'd0,
    ROLE_LRU_LEAD = 2'd1,
    ROLE_BIP_LEAD = 2'd2
  } set_role_e;
endpackage

// File: rtl/sdip_leader_map.sv
module sdip_leader_map
  import sdip_pkg::*;
#(
  parameter int SET_W = 10
) (
  input  logic [SET_W-1:0] set_idx,
  output set_role_e        role
);
  localparam int HALF_W = SET_W / 2;

  logic [HALF_W-1:0] lo_fld;
  logic [HALF_W-1:0] hi_fld;

  assign lo_fld = set_idx[HALF_W-1:0];
  assign hi_fld = set_idx[2*HALF_W-1:HALF_W];

  // Equal halves pick plain leaders, inverted halves pick bimodal leaders.
  always_comb begin
    if (lo_fld == hi_fld)       role = ROLE_LRU_LEAD;
    else if (lo_fld == ~hi_fld) role = ROLE_BIP_LEAD;
    else                        role = ROLE_FOLLOW;
  end
endmodule

// File: rtl/sdip_selector.sv
module sdip_selector #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up,
  input  logic             down,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] MID_V = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] TOP_V = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt <= MID_V;
    else if (up && (cnt != TOP_V))     cnt <= cnt + 1'b1;
    else if (down && (cnt != '0))      cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/sdip_throttle.sv
module sdip_throttle #(
  parameter int                LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS   = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED   = 16'hACE1,
  parameter int                EPS_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [LFSR_W-1:0] state,
  output logic              take_mru
);
  logic fb;

  assign fb       = ^(state & TAPS);
  assign take_mru = (state[EPS_W-1:0] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= {state[LFSR_W-2:0], fb};
  end
endmodule

// File: rtl/sdip_insert_ctrl.sv
module sdip_insert_ctrl
  import sdip_pkg::*;
#(
  parameter int                SET_W     = 10,
  parameter int                CNT_W     = 10,
  parameter int                LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter int                EPS_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic [SET_W-1:0] acc_set,
  input  logic             acc_hit,
  output logic             dec_valid,
  input  logic             dec_ready,
  output logic             dec_fill,
  output logic             dec_ins_mru,
  output logic             dec_promote,
  output logic             pol_bip
);
  set_role_e         role;
  logic [CNT_W-1:0]  sel_cnt;
  logic [LFSR_W-1:0] thr_state;
  logic              thr_mru;
  logic              fire;
  logic              miss_fire;
  logic              use_bip;

  sdip_leader_map #(.SET_W(SET_W)) u_map (
    .set_idx (acc_set),
    .role    (role)
  );

  assign fire      = acc_valid && dec_ready;
  assign miss_fire = fire && !acc_hit;

  sdip_selector #(.CNT_W(CNT_W)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .up    (miss_fire && (role == ROLE_LRU_LEAD)),
    .down  (miss_fire && (role == ROLE_BIP_LEAD)),
    .cnt   (sel_cnt)
  );

  sdip_throttle #(
    .LFSR_W (LFSR_W),
    .TAPS   (LFSR_TAPS),
    .SEED   (LFSR_SEED),
    .EPS_W  (EPS_W)
  ) u_thr (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (miss_fire),
    .state    (thr_state),
    .take_mru (thr_mru)
  );

  assign pol_bip = sel_cnt[CNT_W-1];

  always_comb begin
    unique case (role)
      ROLE_LRU_LEAD: use_bip = 1'b0;
      ROLE_BIP_LEAD: use_bip = 1'b1;
      default:       use_bip = pol_bip;
    endcase
  end

  assign acc_ready   = dec_ready;
  assign dec_valid   = acc_valid;
  assign dec_fill    = !acc_hit;
  assign dec_promote = acc_hit;
  assign dec_ins_mru = !acc_hit && (!use_bip || thr_mru);
endmodule

// File: rtl/sdip_insert_chk.sv
module sdip_insert_chk
  import sdip_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int LFSR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              dec_ready,
  input logic              acc_hit,
  input set_role_e         role,
  input logic [CNT_W-1:0]  cnt,
  input logic [LFSR_W-1:0] lfsr,
  input logic              dec_ins_mru,
  input logic              dec_promote,
  input logic              pol_bip
);
  localparam logic [CNT_W-1:0] TOP_V = {CNT_W{1'b1}};

  // R2
  ctr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && dec_ready && !acc_hit && role == ROLE_LRU_LEAD && cnt != TOP_V)
      |=> cnt == $past(cnt) + 1'b1);

  // R3
  ctr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && dec_ready && !acc_hit && role == ROLE_BIP_LEAD && cnt != '0)
      |=> cnt == $past(cnt) - 1'b1);

  // R8
  hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && dec_ready && acc_hit) |=> ($stable(cnt) && $stable(lfsr)));

  // R8
  hit_no_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_hit) |-> (dec_promote && !dec_ins_mru));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && dec_ready) |=> ($stable(cnt) && $stable(lfsr)));

  // R10
  follow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && dec_ready && role == ROLE_FOLLOW) |=> $stable(cnt));

  // R5
  follow_lru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit && role == ROLE_FOLLOW && !pol_bip) |-> dec_ins_mru);

  // R7
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);
endmodule

bind sdip_insert_ctrl sdip_insert_chk #(.CNT_W(CNT_W), .LFSR_W(LFSR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .dec_ready   (dec_ready),
  .acc_hit     (acc_hit),
  .role        (role),
  .cnt         (sel_cnt),
  .lfsr        (thr_state),
  .dec_ins_mru (dec_ins_mru),
  .dec_promote (dec_promote),
  .pol_bip     (pol_bip)
);

// File: tb/sdip_insert_ctrl_tb.sv
module sdip_insert_ctrl_tb;
  localparam int SET_W = 10;
  localparam int CNT_W = 10;
  localparam int HALF  = SET_W / 2;
  localparam int HMASK = (1 << HALF) - 1;
  localparam int TOPV  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             acc_valid = 1'b0;
  logic             acc_ready;
  logic [SET_W-1:0] acc_set = '0;
  logic             acc_hit = 1'b0;
  logic             dec_valid;
  logic             dec_ready = 1'b0;
  logic             dec_fill;
  logic             dec_ins_mru;
  logic             dec_promote;
  logic             pol_bip;

  int total = 0;
  int bad = 0;
  int m_cnt;
  logic [15:0] m_lfsr;
  logic [31:0] rng = 32'h1234_5679;

  always #2.5 clk = ~clk;

  sdip_insert_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_set(acc_set), .acc_hit(acc_hit), .dec_valid(dec_valid),
    .dec_ready(dec_ready), .dec_fill(dec_fill), .dec_ins_mru(dec_ins_mru),
    .dec_promote(dec_promote), .pol_bip(pol_bip)
  );

  // R1: 1 plain leader, 2 bimodal leader, 0 follower
  function automatic int role_of(int s);
    int lo, hi;
    lo = s & HMASK;
    hi = (s >> HALF) & HMASK;
    if (lo == hi) return 1;
    if (lo == ((~hi) & HMASK)) return 2;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic acc(int s, bit hit, bit vld, bit rdy, string req);
    int r;
    bit pol, exp_mru;
    @(negedge clk);
    acc_valid = vld; acc_set = s[SET_W-1:0]; acc_hit = hit; dec_ready = rdy;
    #1;
    r = role_of(s);
    pol = (r == 1) ? 1'b0 : (r == 2) ? 1'b1 : m_cnt[CNT_W-1];
    exp_mru = !hit && (!pol || (m_lfsr[4:0] == 5'd0));
    chk(dec_ins_mru === exp_mru, req, "ins_mru", int'(dec_ins_mru), int'(exp_mru));
    chk(dec_promote === hit, "R8", "promote", int'(dec_promote), int'(hit));
    chk(dec_fill === !hit, "R8", "fill", int'(dec_fill), int'(!hit));
    chk(pol_bip === m_cnt[CNT_W-1], "R4", "pol_bip", int'(pol_bip), m_cnt[CNT_W-1]);
    chk(acc_ready === rdy && dec_valid === vld, "R9", "handshake",
        int'({acc_ready, dec_valid}), int'({rdy, vld}));
    if (vld && rdy && !hit) begin
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
      if (r == 1 && m_cnt != TOPV) m_cnt++;
      if (r == 2 && m_cnt != 0) m_cnt--;
    end
  endtask

  function automatic logic [31:0] nxt(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  initial begin : watchdog
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int bip_set;
    bip_set = HMASK << HALF;
    m_cnt = 1 << (CNT_W - 1);
    m_lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R4: reset state
    chk(pol_bip === 1'b1, "R4", "reset pol_bip", int'(pol_bip), 1);
    chk(dec_valid === 1'b0, "R9", "reset dec_valid", int'(dec_valid), 0);

    // R1 R5 R6 R7 R10: miss in every set index
    for (int s = 0; s < (1 << SET_W); s++) acc(s, 1'b0, 1'b1, 1'b1, "R1");

    // R2: drive counter to the top rail and beyond
    for (int i = 0; i < 600; i++) acc(0, 1'b0, 1'b1, 1'b1, "R2");
    for (int s = 1; s < 40; s++) acc(s, 1'b0, 1'b1, 1'b1, "R5");
    for (int i = 0; i < 512; i++) acc(bip_set, 1'b0, 1'b1, 1'b1, "R2");
    for (int s = 1; s < 60; s++) acc(s, 1'b0, 1'b1, 1'b1, "R5");

    // R3: drive counter to the bottom rail and beyond
    for (int i = 0; i < 700; i++) acc(bip_set, 1'b0, 1'b1, 1'b1, "R3");
    for (int i = 0; i < 512; i++) acc(HMASK * ((1 << HALF) + 1) & ((1 << SET_W) - 1),
                                      1'b0, 1'b1, 1'b1, "R3");
    for (int s = 1; s < 60; s++) acc(s, 1'b0, 1'b1, 1'b1, "R6");

    // R8: hits everywhere, then misses expose any drift
    for (int s = 0; s < (1 << SET_W); s += 3) acc(s, 1'b1, 1'b1, 1'b1, "R8");
    for (int s = 2; s < 80; s++) acc(s, 1'b0, 1'b1, 1'b1, "R8");

    // R9: stalled and idle accesses
    for (int i = 0; i < 300; i++) acc(0, 1'b0, 1'b1, 1'b0, "R9");
    for (int i = 0; i < 300; i++) acc(bip_set, 1'b0, 1'b0, 1'b1, "R9");
    for (int s = 2; s < 80; s++) acc(s, 1'b0, 1'b1, 1'b1, "R9");

    // mixed pseudo-random traffic
    for (int i = 0; i < 3000; i++) begin
      int s;
      rng = nxt(rng);
      s = rng[3] ? (rng[4] ? 0 : bip_set) : int'(rng[25:16]);
      if (rng[5] && rng[6]) s = int'({rng[20:16], rng[20:16]});
      acc(s, rng[8] & rng[9], !(rng[10] & rng[11] & rng[12]),
          !(rng[13] & rng[14] & rng[15]), "R6");
    end

    @(negedge clk);
    acc_valid = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule